// File: doc/BRIEF.md
# Fair Two-Direction Feature Selector with Connection History

This block sits between two per-direction feature extractors and a downstream traffic classifier. Each extractor hands over one feature record per frame: source and destination address, source and destination port, protocol number and the TCP SYN flag. The block takes records from the two sides in strict turns, so a flood of short frames on one side cannot stall the other. Each side has a one-deep holding slot with a `ready` output. A record that arrives while the other side is being served waits there until its turn comes.

For every record taken, the block forms a connection key that always names the host on the protected network. Inbound records use the destination address and port. Outbound records use the source address and port. The block then scans a small circular history memory one entry per cycle. It counts the earlier records with the same key, how many of those carried SYN, and how many earlier records share the protocol regardless of key.

When the scan ends, the block emits the current key, protocol and SYN together with the three counts on a one-cycle strobe. It then writes the record into the history at a wrapping write pointer, overwriting the oldest entry once the memory is full. A whole record takes HIST_DEPTH+3 cycles, well inside a fixed per-frame cycle budget.

Top module: `flow_dir_selector`

## Requirements
- R1: After reset `res_valid` is low and both `ib_ready` and `ob_ready` are high.
- R2: A side captures a record on a clock edge where its valid and ready are both high. Its ready is low from that edge until the record is taken for service, and the held record stays unchanged until then.
- R3: The selector checks the inbound side and then the outbound side in turn, whatever the result of each check. When both sides have work, consecutive results alternate direction. A record captured on one side sees at most one result from the other side before its own result appears.
- R4: `res_dir` is 0 for an inbound record and 1 for an outbound record. `res_key_addr`/`res_key_port` carry the destination address/port for inbound records and the source address/port for outbound records.
- R5: `res_match_cnt` equals the number of valid history entries, written before the current record, whose key equals the current key. Slots never written are not counted.
- R6: `res_syn_cnt` equals the number of those key-matching entries whose stored SYN flag is 1.
- R7: `res_proto_cnt` equals the number of valid history entries whose protocol equals the current protocol, whatever their key.
- R8: The history holds HIST_DEPTH records (default 20), written circularly, so the (HIST_DEPTH+1)-th record replaces the oldest. No count ever exceeds HIST_DEPTH or the number of earlier results.
- R9: `res_valid` is a single-cycle strobe. In that cycle `res_proto` and `res_syn` carry the current record's protocol and SYN flag.
- R10: With the block idle, a result appears between HIST_DEPTH+3 and CYCLE_BUDGET (default 26) clock edges after the capturing edge. From the service decision to the result, the block never uses more than CYCLE_BUDGET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ib_valid | input | 1 | Inbound record offered |
| ib_ready | output | 1 | Inbound holding slot empty |
| ib_src_addr | input | ADDR_W | Inbound source address (external host) |
| ib_src_port | input | PORT_W | Inbound source port |
| ib_dst_addr | input | ADDR_W | Inbound destination address (internal host) |
| ib_dst_port | input | PORT_W | Inbound destination port |
| ib_proto | input | PROTO_W | Inbound protocol number |
| ib_syn | input | 1 | Inbound TCP SYN flag |
| ob_valid | input | 1 | Outbound record offered |
| ob_ready | output | 1 | Outbound holding slot empty |
| ob_src_addr | input | ADDR_W | Outbound source address (internal host) |
| ob_src_port | input | PORT_W | Outbound source port |
| ob_dst_addr | input | ADDR_W | Outbound destination address (external host) |
| ob_dst_port | input | PORT_W | Outbound destination port |
| ob_proto | input | PROTO_W | Outbound protocol number |
| ob_syn | input | 1 | Outbound TCP SYN flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_dir | output | 1 | Direction of the result: 0 inbound, 1 outbound |
| res_key_addr | output | ADDR_W | Connection key address (internal host) |
| res_key_port | output | PORT_W | Connection key port |
| res_proto | output | PROTO_W | Protocol of the current record |
| res_syn | output | 1 | SYN flag of the current record |
| res_match_cnt | output | CNT_W | Earlier entries with the same key |
| res_syn_cnt | output | CNT_W | Same-key entries with SYN set |
| res_proto_cnt | output | CNT_W | Earlier entries with the same protocol |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-bit ports, 8-bit protocol, a 20-entry history and a 26-cycle budget. A few hundred records pass through, so the write pointer wraps many times, and the overwrite of the oldest entry is compared against a model of the 20-entry memory. Keys are drawn from four internal hosts and two ports, and protocols from three values, so key matches, SYN counts and protocol counts are frequent. Flood phases on each side, and on both sides together, bring the alternation and starvation bounds within reach.

// File: rtl/flowsel_pkg.sv
`timescale 1ns/1ps
package flowsel_pkg;

   // direction codes, also used as the res_dir encoding
   localparam bit DIR_IN  = 1'b0;
   localparam bit DIR_OUT = 1'b1;

   typedef enum logic [1:0] {
      ST_PICK = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } sel_state_t;

endpackage

// File: rtl/side_hold.sv
`timescale 1ns/1ps
// One-deep holding slot for one traffic direction.
module side_hold #(
   parameter int KEY_W   = 48,
   parameter int PROTO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [KEY_W-1:0]   in_key,
   input  logic [PROTO_W-1:0] in_proto,
   input  logic               in_syn,
   input  logic               take,
   output logic               ready,
   output logic               pend,
   output logic [KEY_W-1:0]   key,
   output logic [PROTO_W-1:0] proto,
   output logic               syn
);

   logic capture;

   assign ready   = !pend;
   assign capture = in_valid && !pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         key   <= '0;
         proto <= '0;
         syn   <= 1'b0;
      end else begin
         if (take) begin
            pend <= 1'b0;
         end else if (capture) begin
            pend <= 1'b1;
         end
         if (capture) begin
            key   <= in_key;
            proto <= in_proto;
            syn   <= in_syn;
         end
      end
   end

endmodule

// File: rtl/hist_ram.sv
`timescale 1ns/1ps
// Synchronous single-port-write, single-port-read history store.
module hist_ram #(
   parameter int WIDTH = 57,
   parameter int DEPTH = 20,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/match_agg.sv
`timescale 1ns/1ps
// Per-entry comparison and running counts for one scan.
module match_agg #(
   parameter int KEY_W   = 48,
   parameter int PROTO_W = 8,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               en,
   input  logic [KEY_W-1:0]   cur_key,
   input  logic [PROTO_W-1:0] cur_proto,
   input  logic [KEY_W-1:0]   ent_key,
   input  logic [PROTO_W-1:0] ent_proto,
   input  logic               ent_syn,
   output logic [CNT_W-1:0]   match_cnt,
   output logic [CNT_W-1:0]   syn_cnt,
   output logic [CNT_W-1:0]   proto_cnt
);

   logic key_hit;
   logic proto_hit;

   assign key_hit   = (ent_key == cur_key);
   assign proto_hit = (ent_proto == cur_proto);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         match_cnt <= '0;
         syn_cnt   <= '0;
         proto_cnt <= '0;
      end else if (en) begin
         if (key_hit) begin
            match_cnt <= match_cnt + 1'b1;
            if (ent_syn) begin
               syn_cnt <= syn_cnt + 1'b1;
            end
         end
         if (proto_hit) begin
            proto_cnt <= proto_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/flow_dir_selector.sv
`timescale 1ns/1ps
module flow_dir_selector
   import flowsel_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int PORT_W       = 16,
   parameter int PROTO_W      = 8,
   parameter int HIST_DEPTH   = 20,
   parameter int CYCLE_BUDGET = 26,
   localparam int KEY_W       = ADDR_W + PORT_W,
   localparam int REC_W       = KEY_W + PROTO_W + 1,
   localparam int CNT_W       = $clog2(HIST_DEPTH + 1),
   localparam int AW          = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1,
   localparam int SC_W        = $clog2(HIST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ib_valid,
   output logic               ib_ready,
   input  logic [ADDR_W-1:0]  ib_src_addr,
   input  logic [PORT_W-1:0]  ib_src_port,
   input  logic [ADDR_W-1:0]  ib_dst_addr,
   input  logic [PORT_W-1:0]  ib_dst_port,
   input  logic [PROTO_W-1:0] ib_proto,
   input  logic               ib_syn,
   input  logic               ob_valid,
   output logic               ob_ready,
   input  logic [ADDR_W-1:0]  ob_src_addr,
   input  logic [PORT_W-1:0]  ob_src_port,
   input  logic [ADDR_W-1:0]  ob_dst_addr,
   input  logic [PORT_W-1:0]  ob_dst_port,
   input  logic [PROTO_W-1:0] ob_proto,
   input  logic               ob_syn,
   output logic               res_valid,
   output logic               res_dir,
   output logic [ADDR_W-1:0]  res_key_addr,
   output logic [PORT_W-1:0]  res_key_port,
   output logic [PROTO_W-1:0] res_proto,
   output logic               res_syn,
   output logic [CNT_W-1:0]   res_match_cnt,
   output logic [CNT_W-1:0]   res_syn_cnt,
   output logic [CNT_W-1:0]   res_proto_cnt
);

   // ---------------- elaboration checks ----------------
   if (HIST_DEPTH < 2) begin : g_bad_depth
      $error("flow_dir_selector: HIST_DEPTH must be at least 2");
   end
   if (CYCLE_BUDGET < HIST_DEPTH + 3) begin : g_bad_budget
      $error("flow_dir_selector: CYCLE_BUDGET below HIST_DEPTH+3");
   end
   if (ADDR_W < 1 || PORT_W < 1 || PROTO_W < 1) begin : g_bad_width
      $error("flow_dir_selector: field widths must be positive");
   end

   localparam logic [SC_W-1:0] SC_LAST = SC_W'(HIST_DEPTH);
   localparam logic [AW-1:0]   WP_LAST = AW'(HIST_DEPTH - 1);

   // ---------------- per-direction holding slots ----------------
   logic [1:0]         ext_valid;
   logic [PROTO_W-1:0] ext_proto [2];
   logic [1:0]         ext_syn;
   logic [1:0]         take;
   logic [1:0]         pend;
   logic [1:0]         rdy;
   logic [KEY_W-1:0]   h_key   [2];
   logic [PROTO_W-1:0] h_proto [2];
   logic [1:0]         h_syn;

   assign ext_valid    = {ob_valid, ib_valid};
   assign ext_proto[0] = ib_proto;
   assign ext_proto[1] = ob_proto;
   assign ext_syn      = {ob_syn, ib_syn};
   assign ib_ready     = rdy[0];
   assign ob_ready     = rdy[1];

   // external-side fields never form the key
   logic unused_ext_fields;
   assign unused_ext_fields = ^{ib_src_addr, ib_src_port, ob_dst_addr, ob_dst_port};

   for (genvar s = 0; s < 2; s++) begin : g_side
      logic [KEY_W-1:0] side_key;
      if (s == int'(DIR_IN)) begin : g_dst_key
         assign side_key = {ib_dst_addr, ib_dst_port};
      end else begin : g_src_key
         assign side_key = {ob_src_addr, ob_src_port};
      end
      side_hold #(
         .KEY_W   (KEY_W),
         .PROTO_W (PROTO_W)
      ) u_hold (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (ext_valid[s]),
         .in_key   (side_key),
         .in_proto (ext_proto[s]),
         .in_syn   (ext_syn[s]),
         .take     (take[s]),
         .ready    (rdy[s]),
         .pend     (pend[s]),
         .key      (h_key[s]),
         .proto    (h_proto[s]),
         .syn      (h_syn[s])
      );
   end

   // ---------------- selection and scan control ----------------
   sel_state_t         state;
   logic               turn;
   logic [SC_W-1:0]    sc;
   logic               rd_en_q;
   logic               ent_vld_q;
   logic [AW-1:0]      wptr;
   logic [HIST_DEPTH-1:0] slot_vld;
   logic               cur_dir;
   logic [KEY_W-1:0]   cur_key;
   logic [PROTO_W-1:0] cur_proto;
   logic               cur_syn;
   logic               scan_live;
   logic [AW-1:0]      raddr;
   logic               slot_vld_at;
   logic [KEY_W-1:0]   res_key;

   // a side is served only on its own turn of the pick state
   assign take[0] = (state == ST_PICK) && (turn == DIR_IN)  && pend[0];
   assign take[1] = (state == ST_PICK) && (turn == DIR_OUT) && pend[1];

   assign scan_live   = (state == ST_SCAN) && (sc < SC_LAST);
   assign raddr       = scan_live ? sc[AW-1:0] : '0;
   assign slot_vld_at = scan_live ? slot_vld[raddr] : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ST_PICK;
         turn          <= DIR_IN;
         sc            <= '0;
         rd_en_q       <= 1'b0;
         ent_vld_q     <= 1'b0;
         wptr          <= '0;
         slot_vld      <= '0;
         cur_dir       <= DIR_IN;
         cur_key       <= '0;
         cur_proto     <= '0;
         cur_syn       <= 1'b0;
         res_valid     <= 1'b0;
         res_dir       <= DIR_IN;
         res_key       <= '0;
         res_proto     <= '0;
         res_syn       <= 1'b0;
         res_match_cnt <= '0;
         res_syn_cnt   <= '0;
         res_proto_cnt <= '0;
      end else begin
         res_valid <= 1'b0;
         rd_en_q   <= 1'b0;
         ent_vld_q <= 1'b0;
         unique case (state)
            ST_PICK: begin
               turn <= ~turn;
               if (|take) begin
                  cur_dir   <= turn;
                  cur_key   <= h_key[turn];
                  cur_proto <= h_proto[turn];
                  cur_syn   <= h_syn[turn];
                  sc        <= '0;
                  state     <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               rd_en_q   <= scan_live;
               ent_vld_q <= slot_vld_at;
               if (sc == SC_LAST) begin
                  state <= ST_DONE;
               end else begin
                  sc <= sc + 1'b1;
               end
            end
            ST_DONE: begin
               slot_vld[wptr] <= 1'b1;
               wptr           <= (wptr == WP_LAST) ? '0 : wptr + 1'b1;
               res_valid      <= 1'b1;
               res_dir        <= cur_dir;
               res_key        <= cur_key;
               res_proto      <= cur_proto;
               res_syn        <= cur_syn;
               res_match_cnt  <= agg_match;
               res_syn_cnt    <= agg_syn;
               res_proto_cnt  <= agg_proto;
               state          <= ST_PICK;
            end
            default: state <= ST_PICK;
         endcase
      end
   end

   assign res_key_addr = res_key[KEY_W-1:PORT_W];
   assign res_key_port = res_key[PORT_W-1:0];

   // ---------------- history memory ----------------
   logic [REC_W-1:0] rd_rec;
   logic [CNT_W-1:0] agg_match;
   logic [CNT_W-1:0] agg_syn;
   logic [CNT_W-1:0] agg_proto;

   hist_ram #(
      .WIDTH (REC_W),
      .DEPTH (HIST_DEPTH)
   ) u_hist (
      .clk   (clk),
      .we    (state == ST_DONE),
      .waddr (wptr),
      .wdata ({cur_key, cur_proto, cur_syn}),
      .raddr (raddr),
      .rdata (rd_rec)
   );

   // ---------------- aggregation ----------------
   match_agg #(
      .KEY_W   (KEY_W),
      .PROTO_W (PROTO_W),
      .CNT_W   (CNT_W)
   ) u_agg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (|take),
      .en        (rd_en_q && ent_vld_q),
      .cur_key   (cur_key),
      .cur_proto (cur_proto),
      .ent_key   (rd_rec[REC_W-1 -: KEY_W]),
      .ent_proto (rd_rec[PROTO_W:1]),
      .ent_syn   (rd_rec[0]),
      .match_cnt (agg_match),
      .syn_cnt   (agg_syn),
      .proto_cnt (agg_proto)
   );

endmodule

// File: rtl/flowsel_chk.sv
`timescale 1ns/1ps
module flowsel_chk #(
   parameter int DEPTH  = 20,
   parameter int CNT_W  = 5,
   parameter int BUDGET = 26,
   localparam int LAT_W = $clog2(BUDGET + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             res_valid,
   input logic [CNT_W-1:0] res_match_cnt,
   input logic [CNT_W-1:0] res_syn_cnt,
   input logic [CNT_W-1:0] res_proto_cnt,
   input logic             ib_valid,
   input logic             ib_ready,
   input logic             ob_valid,
   input logic             ob_ready,
   input logic [1:0]       take,
   input logic [1:0]       pend
);

   localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
   localparam logic [LAT_W-1:0] BUDGET_C = LAT_W'(BUDGET);
   localparam logic [LAT_W-1:0] LAT_MAX  = {LAT_W{1'b1}};

   logic [CNT_W-1:0] filled;
   logic [LAT_W-1:0] lat;
   logic             busy;
   logic             owed_q;
   logic             owed_dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filled     <= '0;
         lat        <= '0;
         busy       <= 1'b0;
         owed_q     <= 1'b0;
         owed_dir_q <= 1'b0;
      end else begin
         if (res_valid && filled != DEPTH_C) begin
            filled <= filled + 1'b1;
         end
         if (|take) begin
            busy <= 1'b1;
            lat  <= LAT_W'(1);
         end else if (res_valid) begin
            busy <= 1'b0;
         end else if (busy && lat != LAT_MAX) begin
            lat <= lat + 1'b1;
         end
         if (|take) begin
            owed_q     <= take[1] ? pend[0] : pend[1];
            owed_dir_q <= ~take[1];
         end
      end
   end

   // R9
   res_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R6
   syn_within_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_syn_cnt <= res_match_cnt);

   // R8
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_match_cnt <= DEPTH_C && res_proto_cnt <= DEPTH_C));

   // R8
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_match_cnt <= filled && res_proto_cnt <= filled));

   // R2
   ib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_valid && ib_ready) |=> !ib_ready);

   // R2
   ob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_valid && ob_ready) |=> !ob_ready);

   // R3
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|take) && owed_q) |-> take[owed_dir_q]);

   // R3
   one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));

   // R10
   budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (busy && lat <= BUDGET_C));

endmodule

bind flow_dir_selector flowsel_chk #(
   .DEPTH  (HIST_DEPTH),
   .CNT_W  (CNT_W),
   .BUDGET (CYCLE_BUDGET)
) u_flowsel_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .res_valid     (res_valid),
   .res_match_cnt (res_match_cnt),
   .res_syn_cnt   (res_syn_cnt),
   .res_proto_cnt (res_proto_cnt),
   .ib_valid      (ib_valid),
   .ib_ready      (ib_ready),
   .ob_valid      (ob_valid),
   .ob_ready      (ob_ready),
   .take          (take),
   .pend          (pend)
);

// File: tb/flow_dir_selector_tb_top.sv
`timescale 1ns/1ps
module flow_dir_selector_tb_top;

   localparam int ADDR_W = 32;
   localparam int PORT_W = 16;
   localparam int PROTO_W = 8;
   localparam int DEPTH  = 20;
   localparam int BUDGET = 26;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   logic               ib_valid, ob_valid, ib_ready, ob_ready;
   logic [ADDR_W-1:0]  ib_src_addr, ib_dst_addr, ob_src_addr, ob_dst_addr;
   logic [PORT_W-1:0]  ib_src_port, ib_dst_port, ob_src_port, ob_dst_port;
   logic [PROTO_W-1:0] ib_proto, ob_proto;
   logic               ib_syn, ob_syn;
   logic               res_valid, res_dir, res_syn;
   logic [ADDR_W-1:0]  res_key_addr;
   logic [PORT_W-1:0]  res_key_port;
   logic [PROTO_W-1:0] res_proto;
   logic [CNT_W-1:0]   res_match_cnt, res_syn_cnt, res_proto_cnt;

   flow_dir_selector #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PROTO_W(PROTO_W),
      .HIST_DEPTH(DEPTH), .CYCLE_BUDGET(BUDGET)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ib_valid(ib_valid), .ib_ready(ib_ready),
      .ib_src_addr(ib_src_addr), .ib_src_port(ib_src_port),
      .ib_dst_addr(ib_dst_addr), .ib_dst_port(ib_dst_port),
      .ib_proto(ib_proto), .ib_syn(ib_syn),
      .ob_valid(ob_valid), .ob_ready(ob_ready),
      .ob_src_addr(ob_src_addr), .ob_src_port(ob_src_port),
      .ob_dst_addr(ob_dst_addr), .ob_dst_port(ob_dst_port),
      .ob_proto(ob_proto), .ob_syn(ob_syn),
      .res_valid(res_valid), .res_dir(res_dir),
      .res_key_addr(res_key_addr), .res_key_port(res_key_port),
      .res_proto(res_proto), .res_syn(res_syn),
      .res_match_cnt(res_match_cnt), .res_syn_cnt(res_syn_cnt),
      .res_proto_cnt(res_proto_cnt)
   );

   typedef struct packed {
      logic [47:0] key;
      logic [7:0]  proto;
      logic        syn;
      logic        timed;
      logic [31:0] stamp;
      logic [31:0] other_res;
   } exp_t;

   exp_t q_side [2][$];
   exp_t cur_exp [2];
   bit   drv [2];
   int   pct [2];
   bit   dgo [2];
   exp_t dreq [2];
   logic [1:0] rdy_prev;

   int  n_chk = 0;
   int  n_fail = 0;
   int  cyc = 0;
   bit  timeout = 1'b0;
   bit  prev_res = 1'b0;
   bit  alt_mode = 1'b0;
   int  last_dir = -1;
   int  n_res [2];
   int  n_total = 0;

   logic [47:0] m_key [DEPTH];
   logic [7:0]  m_proto [DEPTH];
   bit          m_syn [DEPTH];
   bit          m_vld [DEPTH];
   int          m_wp = 0;

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_ok(string req, string what, bit ok, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int model_match(logic [47:0] k);
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_key[i] == k) n++;
      return n;
   endfunction

   function automatic int model_syn(logic [47:0] k);
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_key[i] == k && m_syn[i]) n++;
      return n;
   endfunction

   function automatic int model_proto(logic [7:0] p);
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_proto[i] == p) n++;
      return n;
   endfunction

   function automatic int model_fill();
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (m_vld[i]) n++;
      return n;
   endfunction

   // put one record on a side; key fields follow R4
   task automatic put(int s, logic [31:0] a, logic [15:0] p, logic [31:0] ja,
                      logic [15:0] jp, logic [7:0] pr, logic sy, logic timed);
      exp_t e;
      e = '0;
      e.key = {a, p};
      e.proto = pr;
      e.syn = sy;
      e.timed = timed;
      cur_exp[s] = e;
      drv[s] = 1'b1;
      if (s == 0) begin
         ib_dst_addr = a;  ib_dst_port = p;
         ib_src_addr = ja; ib_src_port = jp;
         ib_proto = pr;    ib_syn = sy;
      end else begin
         ob_src_addr = a;  ob_src_port = p;
         ob_dst_addr = ja; ob_dst_port = jp;
         ob_proto = pr;    ob_syn = sy;
      end
   endtask

   task automatic put_random(int s);
      logic [31:0] a;
      logic [15:0] p;
      logic [7:0]  pr;
      int sel;
      a = 32'h0A00_0001 + 32'($urandom_range(0, 3));
      p = ($urandom_range(0, 1) == 1) ? 16'd80 : 16'd443;
      sel = $urandom_range(0, 2);
      pr = (sel == 0) ? 8'd6 : (sel == 1) ? 8'd17 : 8'd1;
      put(s, a, p, $urandom, 16'($urandom), pr, 1'($urandom_range(0, 1)), 1'b0);
   endtask

   task automatic take_result();
      exp_t e;
      int d;
      int em, es, ep;
      d = int'(res_dir);
      if (q_side[d].size() == 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 result on direction %0d with nothing pending: actual 1 expected 0", d);
         return;
      end
      e = q_side[d].pop_front();
      chk("R4", "key address", res_key_addr, e.key[47:16]);
      chk("R4", "key port", res_key_port, e.key[15:0]);
      chk("R9", "protocol", res_proto, e.proto);
      chk("R9", "syn flag", res_syn, e.syn);
      em = model_match(e.key);
      es = model_syn(e.key);
      ep = model_proto(e.proto);
      if (model_fill() == DEPTH) begin
         chk("R8", "match count, history full", res_match_cnt, em);
      end else begin
         chk("R5", "match count", res_match_cnt, em);
      end
      chk("R6", "syn count", res_syn_cnt, es);
      chk("R7", "protocol count", res_proto_cnt, ep);
      if (e.timed) begin
         chk_ok("R10", "idle latency", (cyc - int'(e.stamp)) >= DEPTH + 3 &&
                (cyc - int'(e.stamp)) <= BUDGET, cyc - int'(e.stamp), BUDGET);
      end
      chk_ok("R3", "other-side results while waiting",
             (n_res[1-d] - int'(e.other_res)) <= 1, n_res[1-d] - int'(e.other_res), 1);
      if (alt_mode && last_dir >= 0) begin
         chk_ok("R3", "direction alternation", d != last_dir, d, 1 - last_dir);
      end
      last_dir = d;
      m_key[m_wp] = e.key;
      m_proto[m_wp] = e.proto;
      m_syn[m_wp] = e.syn;
      m_vld[m_wp] = 1'b1;
      m_wp = (m_wp + 1) % DEPTH;
      n_res[d]++;
      n_total++;
   endtask

   task automatic step();
      exp_t e;
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) timeout = 1'b1;
      for (int s = 0; s < 2; s++) begin
         if (drv[s] && rdy_prev[s]) begin
            e = cur_exp[s];
            e.stamp = 32'(cyc);
            e.other_res = 32'(n_res[1-s]);
            q_side[s].push_back(e);
            drv[s] = 1'b0;
            chk("R2", "ready after capture", (s == 0) ? ib_ready : ob_ready, 0);
         end
      end
      if (prev_res) chk("R9", "strobe width", res_valid, 0);
      prev_res = res_valid;
      if (res_valid) take_result();
      for (int s = 0; s < 2; s++) begin
         if (!drv[s]) begin
            if (dgo[s]) begin
               e = dreq[s];
               dgo[s] = 1'b0;
               drv[s] = 1'b1;
               cur_exp[s] = e;
               if (s == 0) begin
                  ib_dst_addr = e.key[47:16]; ib_dst_port = e.key[15:0];
                  ib_proto = e.proto; ib_syn = e.syn;
               end else begin
                  ob_src_addr = e.key[47:16]; ob_src_port = e.key[15:0];
                  ob_proto = e.proto; ob_syn = e.syn;
               end
            end else if (pct[s] > 0 && $urandom_range(0, 99) < pct[s]) begin
               put_random(s);
            end
         end
      end
      ib_valid = drv[0];
      ob_valid = drv[1];
      rdy_prev = {ob_ready, ib_ready};
   endtask

   task automatic run(int n);
      for (int i = 0; i < n && !timeout; i++) step();
   endtask

   task automatic wait_total(int target);
      while (n_total < target && !timeout) step();
   endtask

   // directed record: junk external fields are driven directly
   task automatic directed(int s, logic [31:0] a, logic [15:0] p, logic [31:0] ja,
                           logic [15:0] jp, logic [7:0] pr, logic sy);
      int target;
      target = n_total + 1;
      put(s, a, p, ja, jp, pr, sy, 1'b1);
      ib_valid = drv[0];
      ob_valid = drv[1];
      wait_total(target);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd51277);
      ib_valid = 0; ob_valid = 0;
      ib_src_addr = 0; ib_dst_addr = 0; ob_src_addr = 0; ob_dst_addr = 0;
      ib_src_port = 0; ib_dst_port = 0; ob_src_port = 0; ob_dst_port = 0;
      ib_proto = 0; ob_proto = 0; ib_syn = 0; ob_syn = 0;
      for (int s = 0; s < 2; s++) begin
         drv[s] = 0; pct[s] = 0; dgo[s] = 0; n_res[s] = 0;
         cur_exp[s] = '0; dreq[s] = '0;
      end
      for (int i = 0; i < DEPTH; i++) begin
         m_vld[i] = 0; m_key[i] = '0; m_proto[i] = '0; m_syn[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "res_valid after reset", res_valid, 0);
      chk("R1", "ib_ready after reset", ib_ready, 1);
      chk("R1", "ob_ready after reset", ob_ready, 1);
      rdy_prev = 2'b11;

      // R4 R5 R10: first inbound record, empty history
      directed(0, 32'h0A00_0001, 16'd80, 32'hC0A8_0005, 16'd1234, 8'd6, 1'b1);
      // R4 R5 R6 R7: outbound with the same internal host as source
      directed(1, 32'h0A00_0001, 16'd80, 32'h0808_0808, 16'd53, 8'd6, 1'b0);
      // R4 R7: inbound whose source equals the known key must not match
      directed(0, 32'h0A00_0002, 16'd22, 32'h0A00_0001, 16'd80, 8'd17, 1'b0);
      // R4: outbound whose destination equals a known key must not match
      directed(1, 32'h0A00_0003, 16'd443, 32'h0A00_0002, 16'd22, 8'd1, 1'b1);
      run(5);

      // R3: inbound flood, sparse outbound
      pct[0] = 100; pct[1] = 15;
      run(3000);
      // R3: both sides flooded, strict alternation
      pct[0] = 100; pct[1] = 100;
      run(60);
      alt_mode = 1'b1;
      last_dir = -1;
      run(1500);
      alt_mode = 1'b0;
      // R3: outbound flood, sparse inbound
      pct[0] = 15; pct[1] = 100;
      run(3000);
      // drain
      pct[0] = 0; pct[1] = 0;
      while (!timeout && (drv[0] || drv[1] || q_side[0].size() != 0 ||
                          q_side[1].size() != 0)) step();
      run(30);
      chk("R3", "inbound records left unserved", q_side[0].size(), 0);
      chk("R3", "outbound records left unserved", q_side[1].size(), 0);
      chk_ok("R8", "history wrapped", n_total > 2 * DEPTH, n_total, 2 * DEPTH);

      if (timeout) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, WATCHDOG);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule